// File: doc/BRIEF.md
# Double-Buffered Framebuffer Fetch Address Generator

This block turns a running pixel position into the word address to fetch from a linear, row-major framebuffer. Rows follow each other with no padding, so the pixel position is one index that counts up from zero at the start of each frame. The block holds which of two framebuffer base addresses is active. When swapping is enabled, it alternates between them on successive frames, so software can draw into one buffer while the other is being scanned out.

The byte offset of a pixel depends on the colour depth. At 8 bits per pixel a word holds four pixels. At 16 bits it holds two. At 24 bits, four pixels are packed into three words. The block also outputs the byte base of the colour lookup table half that goes with the current frame. A separate enable lets that half follow the video bank or stay where it is.

The surrounding fetch engine pulses a frame-start strobe once per frame and a pixel-advance strobe once per pixel. It reads the word address, the bank bit and the lookup base at the outputs. Those outputs follow the base and depth inputs in the same cycle.

Top module: `dbfa_top`

## Requirements
- R1: After synchronous reset, the video bank is 0, the lookup bank is 0 and the pixel index is 0. The word address therefore equals base A >> 2 and the lookup base is 0x800.
- R2: While `bank_sel` is 0 the word address is built on `base_a`. While it is 1 the address is built on `base_b`.
- R3: On a clock edge with `frame_start` high, the video bank inverts if `vid_swap_en` is 1 and keeps its value if it is 0. Without `frame_start` the bank never changes.
- R4: On a clock edge with `frame_start` high and `lut_swap_en` at 1, the lookup bank takes the video bank's new value. In every other cycle the lookup bank holds. `lut_base` is 0x800 for lookup bank 0 and 0xC00 for lookup bank 1.
- R5: A clock edge with `frame_start` high sets the pixel index to 0, even if `pix_adv` is also high.
- R6: A clock edge with `pix_adv` high and `frame_start` low adds one to the pixel index. With both strobes low, the index and the address hold.
- R7: With `depth_sel` set to 0 (8-bit grey) or 1 (8-bit palette), the word offset is the pixel index / 4.
- R8: With `depth_sel` set to 2 (16-bit), the word offset is the pixel index / 2.
- R9: With `depth_sel` set to 3 (24-bit), the word offset is (pixel index / 4) × 3.
- R10: `fetch_word_addr` equals (selected base >> 2) + offset, modulo 2^(AW-2). The two low bits of a base have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_a | input | AW | Byte base of framebuffer bank 0 |
| base_b | input | AW | Byte base of framebuffer bank 1 |
| vid_swap_en | input | 1 | Allow the video bank to alternate at frame start |
| lut_swap_en | input | 1 | Allow the lookup bank to follow the video bank at frame start |
| depth_sel | input | 2 | Colour depth: 0/1 = 8 bpp, 2 = 16 bpp, 3 = 24 bpp |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| pix_adv | input | 1 | One-cycle strobe per displayed pixel |
| fetch_word_addr | output | AW-2 | Word address of the word holding the current pixel group |
| bank_sel | output | 1 | Active video bank |
| lut_base | output | AW | Byte base of the active lookup table half |

## Verification
The hardest cases to reach are the ones where the lookup bank and the video bank disagree. Getting there requires frames that swap video with the lookup swap disabled, followed by frames that re-enable it. Another hard case is a frame start that lands in the same cycle as a pixel advance. The stimulus walks through directed sequences of frames that set each enable combination on purpose. It then runs a long stretch with rare random frame starts and random depth and enable changes, so that the index grows past several 4-pixel groups in every depth. A behavioural reference model tracks the bank, lookup bank and index and is compared on every cycle.

// File: rtl/dbfa_pkg.sv
package dbfa_pkg;

    typedef enum logic [1:0] {
        DEPTH_GREY8  = 2'd0,
        DEPTH_PAL8   = 2'd1,
        DEPTH_RGB16  = 2'd2,
        DEPTH_RGB24  = 2'd3
    } depth_e;

    typedef struct packed {
        logic vid;
        logic lut;
    } bank_state_t;

    localparam logic [11:0] LUT_HALF0_BYTE = 12'h800;
    localparam logic [11:0] LUT_HALF1_BYTE = 12'hC00;

    function automatic logic [11:0] lut_half_base(input logic half);
        return half ? LUT_HALF1_BYTE : LUT_HALF0_BYTE;
    endfunction

endpackage

// File: rtl/dbfa_bank_ctrl.sv
module dbfa_bank_ctrl
    import dbfa_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_start,
    input  logic        vid_swap_en,
    input  logic        lut_swap_en,
    output bank_state_t banks
);

    bank_state_t banks_q;
    logic        vid_next;

    assign vid_next = banks_q.vid ^ vid_swap_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            banks_q <= '0;
        end else if (frame_start) begin
            banks_q.vid <= vid_next;
            if (lut_swap_en)
                banks_q.lut <= vid_next;
        end
    end

    assign banks = banks_q;

    AST_BANK_QUIET: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(banks_q.vid)); // R3
    AST_BANK_FLIP: assert property (@(posedge clk) disable iff (rst)
        (frame_start && vid_swap_en) |=> (banks_q.vid != $past(banks_q.vid))); // R3
    AST_BANK_PINNED: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !vid_swap_en) |=> $stable(banks_q.vid)); // R3
    AST_LUT_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (frame_start && lut_swap_en) |=> (banks_q.lut == banks_q.vid)); // R4
    AST_LUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(frame_start && lut_swap_en) |=> $stable(banks_q.lut)); // R4

endmodule

// File: rtl/dbfa_pix_counter.sv
module dbfa_pix_counter #(
    parameter int IDXW = 20
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            frame_start,
    input  logic            pix_adv,
    output logic [IDXW-1:0] pix_idx
);

    logic [IDXW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst || frame_start)
            idx_q <= '0;
        else if (pix_adv)
            idx_q <= idx_q + 1'b1;
    end

    assign pix_idx = idx_q;

    AST_IDX_RESTART: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (idx_q == '0)); // R5
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && pix_adv) |=> (idx_q == $past(idx_q) + 1'b1)); // R6
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && !pix_adv) |=> $stable(idx_q)); // R6

endmodule

// File: rtl/dbfa_offset_calc.sv
module dbfa_offset_calc
    import dbfa_pkg::*;
#(
    parameter int IDXW = 20,
    localparam int OFFW = IDXW + 1
) (
    input  logic [IDXW-1:0] pix_idx,
    input  depth_e          depth,
    output logic [OFFW-1:0] word_off
);

    logic [OFFW-1:0] quad;
    logic [OFFW-1:0] pair;

    assign quad = OFFW'(pix_idx >> 2);
    assign pair = OFFW'(pix_idx >> 1);

    always_comb begin
        unique case (depth)
            DEPTH_GREY8, DEPTH_PAL8: word_off = quad;
            DEPTH_RGB16:             word_off = pair;
            DEPTH_RGB24:             word_off = quad + (quad << 1);
            default:                 word_off = quad;
        endcase
    end

    AST_OFF_BOUND: assert final (word_off <= OFFW'(3) * quad || depth == DEPTH_RGB16); // R9

endmodule

// File: rtl/dbfa_top.sv
module dbfa_top
    import dbfa_pkg::*;
#(
    parameter int AW   = 32,
    parameter int IDXW = 20,
    localparam int WAW  = AW - 2,
    localparam int OFFW = IDXW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] base_a,
    input  logic [AW-1:0] base_b,
    input  logic          vid_swap_en,
    input  logic          lut_swap_en,
    input  logic [1:0]    depth_sel,
    input  logic          frame_start,
    input  logic          pix_adv,
    output logic [WAW-1:0] fetch_word_addr,
    output logic          bank_sel,
    output logic [AW-1:0] lut_base
);

    bank_state_t     banks;
    logic [IDXW-1:0] pix_idx;
    logic [OFFW-1:0] word_off;
    logic [WAW-1:0]  base_word;

    dbfa_bank_ctrl u_bank (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .vid_swap_en (vid_swap_en),
        .lut_swap_en (lut_swap_en),
        .banks       (banks)
    );

    dbfa_pix_counter #(.IDXW(IDXW)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .pix_adv     (pix_adv),
        .pix_idx     (pix_idx)
    );

    dbfa_offset_calc #(.IDXW(IDXW)) u_off (
        .pix_idx  (pix_idx),
        .depth    (depth_e'(depth_sel)),
        .word_off (word_off)
    );

    assign base_word = banks.vid ? base_b[AW-1:2] : base_a[AW-1:2];

    generate
        if (WAW > OFFW) begin : g_wide
            assign fetch_word_addr = base_word + {{(WAW-OFFW){1'b0}}, word_off};
        end else begin : g_narrow
            assign fetch_word_addr = base_word + word_off[WAW-1:0];
        end
    endgenerate

    assign bank_sel = banks.vid;
    assign lut_base = {{(AW-12){1'b0}}, lut_half_base(banks.lut)};

    AST_LUT_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (lut_base == AW'(12'h800)) || (lut_base == AW'(12'hC00))); // R4
    AST_FRAME_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (fetch_word_addr == (bank_sel ? base_b[AW-1:2] : base_a[AW-1:2]))); // R5

endmodule

// File: tb/dbfa_top_test.sv
module dbfa_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int WAW = AW - 2;
    localparam int WATCHDOG = 100000;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [AW-1:0]  base_a = 32'h0001_0003;
    logic [AW-1:0]  base_b = 32'h0004_2000;
    logic           vid_swap_en = 1'b0;
    logic           lut_swap_en = 1'b0;
    logic [1:0]     depth_sel = 2'd0;
    logic           frame_start = 1'b0;
    logic           pix_adv = 1'b0;
    logic [WAW-1:0] fetch_word_addr;
    logic           bank_sel;
    logic [AW-1:0]  lut_base;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 0;

    int m_bank = 0;
    int m_lut = 0;
    longint m_idx = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbfa_top uut (
        .clk(clk), .rst(rst), .base_a(base_a), .base_b(base_b),
        .vid_swap_en(vid_swap_en), .lut_swap_en(lut_swap_en),
        .depth_sel(depth_sel), .frame_start(frame_start), .pix_adv(pix_adv),
        .fetch_word_addr(fetch_word_addr), .bank_sel(bank_sel), .lut_base(lut_base)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic longint exp_addr();
        longint b;
        longint off;
        b = (m_bank != 0) ? longint'(base_b) : longint'(base_a);
        case (depth_sel)
            2'd2:    off = m_idx / 2;
            2'd3:    off = (m_idx / 4) * 3;
            default: off = m_idx / 4;
        endcase
        return ((b / 4) + off) % (longint'(1) << WAW);
    endfunction

    // drive inputs at the falling edge, compare, then advance the model to the next rising edge
    task automatic cyc(input bit fs, input bit adv);
        string at;
        @(negedge clk);
        frame_start = fs;
        pix_adv = adv;
        #1;
        if (!rst) begin
            at = (depth_sel == 2'd2) ? "R8" : (depth_sel == 2'd3) ? "R9" : "R7";
            chk(at, longint'(fetch_word_addr), exp_addr());
            chk("R3", longint'(bank_sel), longint'(m_bank));
            chk("R4", longint'(lut_base), (m_lut != 0) ? 64'hC00 : 64'h800);
        end
        if (rst) begin
            m_bank = 0; m_lut = 0; m_idx = 0;
        end else if (fs) begin
            m_bank = m_bank ^ int'(vid_swap_en);
            if (lut_swap_en) m_lut = m_bank;
            m_idx = 0;
        end else if (adv) begin
            m_idx++;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            finished = 1;
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [WAW-1:0] held;
        cyc(0, 0);
        cyc(0, 0);
        rst = 1'b0;
        cyc(0, 0);
        // R1: reset state seen at the ports
        chk("R1", longint'(bank_sel), 0);
        chk("R1", longint'(lut_base), 64'h800);
        chk("R1", longint'(fetch_word_addr), longint'(base_a >> 2));

        // R7 / R8 / R9: walk through each depth over several groups
        for (int d = 0; d < 4; d++) begin
            depth_sel = 2'(d);
            cyc(1, 0);
            for (int p = 0; p < 40; p++) cyc(0, 1);
        end

        // R6: no strobe holds the address
        @(negedge clk);
        held = fetch_word_addr;
        for (int k = 0; k < 5; k++) cyc(0, 0);
        chk("R6", longint'(fetch_word_addr), longint'(held));

        // R3 / R2: swap on, bank flips to B
        vid_swap_en = 1'b1;
        lut_swap_en = 1'b0;
        cyc(1, 0);
        cyc(0, 0);
        chk("R2", longint'(fetch_word_addr), longint'(base_b >> 2));
        chk("R4", longint'(lut_base), 64'h800);

        // R4: lookup follows once enabled
        lut_swap_en = 1'b1;
        cyc(1, 0);
        cyc(0, 0);
        chk("R4", longint'(lut_base), 64'h800);
        cyc(1, 0);
        cyc(0, 0);
        chk("R4", longint'(lut_base), 64'hC00);

        // R5: frame start wins over a simultaneous pixel advance
        for (int p = 0; p < 9; p++) cyc(0, 1);
        cyc(1, 1);
        cyc(0, 0);
        chk("R5", longint'(fetch_word_addr), longint'((bank_sel ? base_b : base_a) >> 2));

        // R3: swap disabled pins the bank
        vid_swap_en = 1'b0;
        for (int f = 0; f < 3; f++) begin
            cyc(1, 0);
            cyc(0, 1);
        end

        // R10: base low bits ignored, changes seen at once
        base_a = 32'h0000_0FFF;
        base_b = 32'h3FFF_FFFE;
        depth_sel = 2'd3;
        cyc(0, 1);
        cyc(0, 1);

        // random stretch
        for (int n = 0; n < 4000; n++) begin
            if (n % 97 == 0) begin
                depth_sel   = 2'($urandom_range(0, 3));
                vid_swap_en = 1'($urandom_range(0, 1));
                lut_swap_en = 1'($urandom_range(0, 1));
                base_a      = $urandom;
                base_b      = $urandom;
            end
            cyc(($urandom_range(0, 63) == 0), ($urandom_range(0, 9) < 7));
        end
        chk("R10", longint'(fetch_word_addr), exp_addr());

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule